// File: doc/BRIEF.md
# Job Ring Occupancy and Index Manager

This block keeps count of two rings in shared memory. Software posts new jobs to an input ring, and a hardware job engine writes results into an output completion ring. Each output entry is a descriptor pointer followed by a 32-bit completion status word. The block does not touch memory. Software programs each ring's size, then reports batches: how many input jobs it has just added, and how many completions it has just consumed. The engine pulses `eng_take` each time it fetches an input job and `eng_done` each time it writes a completion. The block keeps four values:

- the room left in the input ring;
- the number of full output slots;
- the input read index;
- the output write index.

It raises typed error codes when a batch count does not fit. It can stall the engine after an error, and it restarts cleanly on a ring reset command.

A three-state controller sets the engine's permission to work:

- **RUN**: strobes are honoured.
- **CLEAR**: lasts one cycle, right after a reset command. Strobes are ignored.
- **HALT**: entered when an error is raised while stop-on-error is set. Strobes are ignored.

The transitions are:

- *reset command*: any state goes to CLEAR.
- *error with stop-on-error*: RUN or CLEAR goes to HALT.
- *settle*: CLEAR goes to RUN.
- HALT stays in HALT until a reset command.

Register word addresses are:

| Address | Register | Access |
|---|---|---|
| 0 | input size | read/write |
| 1 | jobs added | write |
| 2 | input room | read |
| 3 | input read index | read |
| 4 | output size | read/write |
| 5 | completions consumed | write |
| 6 | output slots full | read |
| 7 | output write index | read |
| 8 | status | read, write 1 to clear |
| 9 | configuration | read/write |
| 10 | command | write |

Writes take effect at the next rising clock edge. Reads are combinational.

Top module: `jr_ring_mgr`

## Requirements
- R1: After reset, the input room, both indices, the full count and the status word read 0, `eng_ready` is 1 and `irq` is 0.
- R2: A ring size keeps only the low 10 bits of the written data. With no pending jobs, input room equals the input size.
- R3: Writing N to address 1 with N not above the input room lowers the room by N.
- R4: Writing N to address 1 with N above the input room leaves the room unchanged. It sets status bit 1 (error) and writes type 9 into status bits 11:8.
- R5: An accepted `eng_take` needs at least one pending job. It advances the input read index, wrapping to 0 when the index would reach the size, and raises the room by 1. A take with nothing pending has no effect.
- R6: An accepted `eng_done` needs a full count below the output size. It advances the output write index, wrapping to 0 at the size, and raises the full count by 1. It also sets status bit 0 unless configuration bit 0 (mask) is set. A done strobe on a full ring has no effect.
- R7: Writing N to address 5 lowers the full count by N when N does not exceed it. Otherwise the count is unchanged, status bit 1 is set and the type field becomes 8.
- R8: Writing 1 to status bit 0 clears it. Writing 1 to bit 1 clears the error flag and the type field. Writing 0 leaves a bit as it was.
- R9: With configuration bit 2 (stop-on-error) set, a raised error drops `eng_ready`. While it is low, engine strobes change no index or count. It stays low until a reset command.
- R10: Writing data with bit 0 set to address 10 clears both counts, both indices, status bits 0 and 1, and sets the type field to 7. Sizes and configuration are kept. `eng_ready` is low for exactly the following cycle.
- R11: `irq` equals (status bit 0 OR status bit 1) AND NOT configuration bit 0.
- R12: A completion accepted in the same cycle as a write-1-to-clear of status bit 0 leaves bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read word address |
| reg_rdata | output | 32 | Read data |
| eng_take | input | 1 | Engine fetched one input job |
| eng_done | input | 1 | Engine wrote one completion |
| eng_ready | output | 1 | Engine may work (state RUN) |
| in_avail | output | 1 | At least one input job pending |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are these:

- a completion landing in the same cycle as a write-1-to-clear of the completion bit;
- engine strobes arriving while the controller is stalled in HALT.

The bench reaches the first by raising `eng_done` during the status write, on a ring that still has a free slot. It reaches the second by enabling stop-on-error, forcing a consume-count overflow, posting a job and then pulsing `eng_take`. It then reads the unchanged read index before issuing the reset command that leads through CLEAR back to RUN.

// File: rtl/jr_pkg.sv
package jr_pkg;
    localparam int REG_AW = 4;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_CLEAR = 2'd1,
        ST_HALT  = 2'd2
    } jr_state_e;

    localparam logic [REG_AW-1:0] A_IN_SIZE   = 4'd0;
    localparam logic [REG_AW-1:0] A_IN_ADD    = 4'd1;
    localparam logic [REG_AW-1:0] A_IN_ROOM   = 4'd2;
    localparam logic [REG_AW-1:0] A_IN_RDIDX  = 4'd3;
    localparam logic [REG_AW-1:0] A_OUT_SIZE  = 4'd4;
    localparam logic [REG_AW-1:0] A_OUT_RMV   = 4'd5;
    localparam logic [REG_AW-1:0] A_OUT_FULL  = 4'd6;
    localparam logic [REG_AW-1:0] A_OUT_WRIDX = 4'd7;
    localparam logic [REG_AW-1:0] A_STATUS    = 4'd8;
    localparam logic [REG_AW-1:0] A_CFG       = 4'd9;
    localparam logic [REG_AW-1:0] A_CMD       = 4'd10;

    localparam int ERR_TW = 4;
    localparam logic [ERR_TW-1:0] ERR_RESET   = 4'd7;
    localparam logic [ERR_TW-1:0] ERR_RMV_OVF = 4'd8;
    localparam logic [ERR_TW-1:0] ERR_ADD_OVF = 4'd9;

    localparam int CFG_W    = 3;
    localparam int CFG_MASK = 0;
    localparam int CFG_COAL = 1;
    localparam int CFG_SOE  = 2;
endpackage

// File: rtl/jr_ctrl_fsm.sv
module jr_ctrl_fsm
    import jr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_reset,
    input  logic      err_raise,
    input  logic      soe,
    output jr_state_e state,
    output logic      eng_ready
);
    jr_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (cmd_reset)              state_nxt = ST_CLEAR;
                else if (err_raise && soe)  state_nxt = ST_HALT;
            end
            ST_CLEAR: begin
                if (cmd_reset)              state_nxt = ST_CLEAR;
                else if (err_raise && soe)  state_nxt = ST_HALT;
                else                        state_nxt = ST_RUN;
            end
            ST_HALT: begin
                if (cmd_reset)              state_nxt = ST_CLEAR;
            end
            default:                        state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        eng_ready = (state == ST_RUN);
    end
endmodule

// File: rtl/jr_occ_track.sv
// Occupancy counter and head index for one ring. SW_FILLS selects the
// direction: software fills and the engine drains (input ring), or the
// engine fills and software drains (output ring).
module jr_occ_track #(
    parameter int SIZE_W   = 10,
    parameter bit SW_FILLS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [SIZE_W-1:0] size,
    input  logic              sw_wr,
    input  logic [SIZE_W-1:0] sw_n,
    input  logic              hw_stb,
    input  logic              hw_en,
    output logic [SIZE_W-1:0] cnt,
    output logic [SIZE_W-1:0] idx,
    output logic [SIZE_W-1:0] room,
    output logic              ovf,
    output logic              hw_acc
);
    localparam logic [SIZE_W-1:0] ONE = SIZE_W'(1);

    logic              sw_ok;
    logic              hw_ok;
    logic [SIZE_W-1:0] cnt_nxt;
    logic [SIZE_W:0]   idx_inc;
    logic [SIZE_W-1:0] idx_nxt;

    assign room = (size > cnt) ? (size - cnt) : '0;

    generate
        if (SW_FILLS) begin : g_sw_fills
            assign sw_ok = (sw_n <= room);
            assign hw_ok = (cnt != '0);
            always_comb begin
                cnt_nxt = cnt;
                if (sw_wr && sw_ok) cnt_nxt = cnt_nxt + sw_n;
                if (hw_acc)         cnt_nxt = cnt_nxt - ONE;
            end
        end else begin : g_hw_fills
            assign sw_ok = (sw_n <= cnt);
            assign hw_ok = (cnt < size);
            always_comb begin
                cnt_nxt = cnt;
                if (sw_wr && sw_ok) cnt_nxt = cnt_nxt - sw_n;
                if (hw_acc)         cnt_nxt = cnt_nxt + ONE;
            end
        end
    endgenerate

    assign ovf     = sw_wr && !sw_ok;
    assign hw_acc  = hw_stb && hw_en && hw_ok;
    assign idx_inc = {1'b0, idx} + {1'b0, ONE};
    assign idx_nxt = (idx_inc >= {1'b0, size}) ? '0 : idx_inc[SIZE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            idx <= '0;
        end else if (clr) begin
            cnt <= '0;
            idx <= '0;
        end else begin
            cnt <= cnt_nxt;
            if (hw_acc) idx <= idx_nxt;
        end
    end
endmodule

// File: rtl/jr_ring_mgr.sv
module jr_ring_mgr
    import jr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [REG_AW-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_take,
    input  logic              eng_done,
    output logic              eng_ready,
    output logic              in_avail,
    output logic              irq
);
    localparam int STAT_W = 8 + ERR_TW;

    logic [SIZE_W-1:0] in_size, out_size;
    logic [CFG_W-1:0]  cfg;
    logic              st_int, st_err;
    logic [ERR_TW-1:0] st_type;

    logic [SIZE_W-1:0] in_pend, in_rd_idx, in_room;
    logic [SIZE_W-1:0] out_full, out_wr_idx, out_room_unused;
    logic              add_ovf, rmv_ovf, take_acc, done_acc;
    jr_state_e         fsm_state;

    logic wr_in_size, wr_out_size, wr_add, wr_rmv, wr_stat, wr_cfg, cmd_reset;
    logic [STAT_W-1:0] stat_word;

    assign wr_in_size  = reg_wr && (reg_addr == A_IN_SIZE);
    assign wr_out_size = reg_wr && (reg_addr == A_OUT_SIZE);
    assign wr_add      = reg_wr && (reg_addr == A_IN_ADD);
    assign wr_rmv      = reg_wr && (reg_addr == A_OUT_RMV);
    assign wr_stat     = reg_wr && (reg_addr == A_STATUS);
    assign wr_cfg      = reg_wr && (reg_addr == A_CFG);
    assign cmd_reset   = reg_wr && (reg_addr == A_CMD) && reg_wdata[0];

    jr_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_reset (cmd_reset),
        .err_raise (add_ovf || rmv_ovf),
        .soe       (cfg[CFG_SOE]),
        .state     (fsm_state),
        .eng_ready (eng_ready)
    );

    jr_occ_track #(.SIZE_W(SIZE_W), .SW_FILLS(1'b1)) u_in_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cmd_reset),
        .size   (in_size),
        .sw_wr  (wr_add),
        .sw_n   (reg_wdata[SIZE_W-1:0]),
        .hw_stb (eng_take),
        .hw_en  (eng_ready),
        .cnt    (in_pend),
        .idx    (in_rd_idx),
        .room   (in_room),
        .ovf    (add_ovf),
        .hw_acc (take_acc)
    );

    jr_occ_track #(.SIZE_W(SIZE_W), .SW_FILLS(1'b0)) u_out_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cmd_reset),
        .size   (out_size),
        .sw_wr  (wr_rmv),
        .sw_n   (reg_wdata[SIZE_W-1:0]),
        .hw_stb (eng_done),
        .hw_en  (eng_ready),
        .cnt    (out_full),
        .idx    (out_wr_idx),
        .room   (out_room_unused),
        .ovf    (rmv_ovf),
        .hw_acc (done_acc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_size  <= '0;
            out_size <= '0;
            cfg      <= '0;
        end else begin
            if (wr_in_size)  in_size  <= reg_wdata[SIZE_W-1:0];
            if (wr_out_size) out_size <= reg_wdata[SIZE_W-1:0];
            if (wr_cfg)      cfg      <= reg_wdata[CFG_W-1:0];
        end
    end

    // Status: reset command first, then write-1-to-clear, then new events.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_int  <= 1'b0;
            st_err  <= 1'b0;
            st_type <= '0;
        end else if (cmd_reset) begin
            st_int  <= 1'b0;
            st_err  <= 1'b0;
            st_type <= ERR_RESET;
        end else begin
            if (wr_stat && reg_wdata[0]) st_int <= 1'b0;
            if (wr_stat && reg_wdata[1]) begin
                st_err  <= 1'b0;
                st_type <= '0;
            end
            if (done_acc && !cfg[CFG_MASK]) st_int <= 1'b1;
            if (add_ovf) begin
                st_err  <= 1'b1;
                st_type <= ERR_ADD_OVF;
            end
            if (rmv_ovf) begin
                st_err  <= 1'b1;
                st_type <= ERR_RMV_OVF;
            end
        end
    end

    assign stat_word = {st_type, 6'b0, st_err, st_int};
    assign in_avail  = (in_pend != '0);
    assign irq       = (st_int || st_err) && !cfg[CFG_MASK];

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            A_IN_SIZE:   reg_rdata = DATA_W'(in_size);
            A_IN_ROOM:   reg_rdata = DATA_W'(in_room);
            A_IN_RDIDX:  reg_rdata = DATA_W'(in_rd_idx);
            A_OUT_SIZE:  reg_rdata = DATA_W'(out_size);
            A_OUT_FULL:  reg_rdata = DATA_W'(out_full);
            A_OUT_WRIDX: reg_rdata = DATA_W'(out_wr_idx);
            A_STATUS:    reg_rdata = DATA_W'(stat_word);
            A_CFG:       reg_rdata = DATA_W'(cfg);
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/jr_ring_mgr_chk.sv
module jr_ring_mgr_chk
    import jr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              eng_ready,
    input jr_state_e         fsm_state,
    input logic [SIZE_W-1:0] in_room,
    input logic [SIZE_W-1:0] out_full,
    input logic [SIZE_W-1:0] in_rd_idx,
    input logic [SIZE_W-1:0] out_wr_idx,
    input logic              st_err,
    input logic [ERR_TW-1:0] st_type
);
    logic cmd;
    assign cmd = reg_wr && (reg_addr == A_CMD) && reg_wdata[0];

    AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_IN_ADD && reg_wdata[SIZE_W-1:0] > in_room)
        |=> (st_err && st_type == ERR_ADD_OVF && in_room == $past(in_room))); // R4

    AST_REMOVE_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_OUT_RMV && reg_wdata[SIZE_W-1:0] > out_full)
        |=> (st_err && st_type == ERR_RMV_OVF)); // R7

    AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd |=> (!eng_ready && out_full == '0 && in_rd_idx == '0 && st_type == ERR_RESET)); // R10

    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_CLEAR && !cmd) |=> (fsm_state != ST_CLEAR)); // R10

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HALT && !cmd) |=> !eng_ready); // R9

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_ready && !cmd) |=> ($stable(out_wr_idx) && $stable(in_rd_idx))); // R9
endmodule

bind jr_ring_mgr jr_ring_mgr_chk #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_chk (.*);

// File: tb/test_jr_ring_mgr.sv
module test_jr_ring_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        eng_take = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_ready, in_avail, irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [3:0]  q_addr[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    jr_ring_mgr i_jr_ring_mgr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .eng_take(eng_take), .eng_done(eng_done), .eng_ready(eng_ready),
        .in_avail(in_avail), .irq(irq)
    );

    // Monitor: pops expected register values and compares them.
    initial begin
        forever begin
            @(negedge clk);
            if (q_addr.size() > 0) begin
                reg_raddr = q_addr[0];
                #1;
                n_chk++;
                if (reg_rdata !== q_exp[0]) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d actual 0x%08h expected 0x%08h",
                             q_tag[0], q_addr[0], reg_rdata, q_exp[0]);
                end
                void'(q_addr.pop_front());
                void'(q_exp.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
        q_addr.push_back(a);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        wait (q_addr.size() == 0);
    endtask

    task automatic chk_bit(input logic act, input logic e, input string tag);
        #1;
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, e);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic take1();
        @(negedge clk);
        eng_take = 1'b1;
        @(negedge clk);
        eng_take = 1'b0;
    endtask

    task automatic done1();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_bit(eng_ready, 1'b1, "R1 ready");
        chk_bit(irq, 1'b0, "R1 irq");
        expect_reg(4'd2, 32'h0, "R1 room");
        expect_reg(4'd3, 32'h0, "R1 rdidx");
        expect_reg(4'd6, 32'h0, "R1 full");
        expect_reg(4'd8, 32'h0, "R1 status");
        // R2 size field truncation
        wr(4'd0, 32'h405);
        expect_reg(4'd0, 32'd5, "R2 size");
        expect_reg(4'd2, 32'd5, "R2 room");
        // R3 add within room
        wr(4'd1, 32'd3);
        expect_reg(4'd2, 32'd2, "R3 room");
        // R4 add overflow
        wr(4'd1, 32'd3);
        expect_reg(4'd2, 32'd2, "R4 room kept");
        expect_reg(4'd8, 32'h902, "R4 status");
        chk_bit(irq, 1'b1, "R11 irq on error");
        // R8 clear error
        wr(4'd8, 32'h2);
        expect_reg(4'd8, 32'h0, "R8 clear err");
        // R5 takes, ignored take, wrap
        for (int i = 0; i < 4; i++) take1();
        expect_reg(4'd3, 32'd3, "R5 rdidx ignore empty");
        expect_reg(4'd2, 32'd5, "R5 room back");
        wr(4'd1, 32'd2);
        take1();
        take1();
        expect_reg(4'd3, 32'd0, "R5 rdidx wrap");
        expect_reg(4'd2, 32'd5, "R5 room");
        // R6 completions, wrap, full ignore
        wr(4'd4, 32'd3);
        for (int i = 0; i < 4; i++) done1();
        expect_reg(4'd6, 32'd3, "R6 full");
        expect_reg(4'd7, 32'd0, "R6 wridx wrap");
        expect_reg(4'd8, 32'h1, "R6 int bit");
        chk_bit(irq, 1'b1, "R11 irq on int");
        wr(4'd8, 32'h1);
        expect_reg(4'd8, 32'h0, "R8 clear int");
        // R7 remove overflow then valid remove
        wr(4'd5, 32'd4);
        expect_reg(4'd6, 32'd3, "R7 full kept");
        expect_reg(4'd8, 32'h802, "R7 status");
        wr(4'd8, 32'h1);
        expect_reg(4'd8, 32'h802, "R8 bit0 write leaves err");
        wr(4'd8, 32'h2);
        wr(4'd5, 32'd2);
        expect_reg(4'd6, 32'd1, "R7 full after remove");
        // R6/R11 masked completion
        wr(4'd9, 32'h1);
        done1();
        expect_reg(4'd6, 32'd2, "R6 masked full");
        expect_reg(4'd8, 32'h0, "R6 masked no int");
        wr(4'd1, 32'd10);
        expect_reg(4'd8, 32'h902, "R4 status masked");
        chk_bit(irq, 1'b0, "R11 irq masked");
        wr(4'd8, 32'h2);
        wr(4'd9, 32'h0);
        // R12 completion beats clear
        wr(4'd5, 32'd1);
        done1();
        expect_reg(4'd8, 32'h1, "R12 int set");
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 32'h1; eng_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; eng_done = 1'b0;
        expect_reg(4'd8, 32'h1, "R12 int kept");
        expect_reg(4'd6, 32'd3, "R12 full");
        expect_reg(4'd7, 32'd0, "R6 wridx wrap again");
        wr(4'd8, 32'h1);
        // R9 stop on error
        wr(4'd9, 32'h4);
        wr(4'd5, 32'd5);
        chk_bit(eng_ready, 1'b0, "R9 stalled");
        expect_reg(4'd8, 32'h802, "R9 status");
        wr(4'd1, 32'd1);
        take1();
        expect_reg(4'd3, 32'd0, "R9 take ignored idx");
        expect_reg(4'd2, 32'd4, "R9 take ignored room");
        chk_bit(eng_ready, 1'b0, "R9 still stalled");
        // R10 reset command
        wr(4'd10, 32'h1);
        chk_bit(eng_ready, 1'b0, "R10 clear cycle");
        @(negedge clk);
        chk_bit(eng_ready, 1'b1, "R10 back to run");
        expect_reg(4'd8, 32'h700, "R10 status");
        expect_reg(4'd6, 32'd0, "R10 full");
        expect_reg(4'd7, 32'd0, "R10 wridx");
        expect_reg(4'd2, 32'd5, "R10 room");
        expect_reg(4'd0, 32'd5, "R10 size kept");
        chk_bit(irq, 1'b0, "R10 irq");
        summary();
    end
endmodule